// File: doc/BRIEF.md
# Trigger-Timing Bus Transmitter

This block drives an eight-line, active-low timing and trigger bus that is synchronous to the system clock. Four lines carry single-cycle command strobes: trigger accept, event-counter reset, bunch-counter reset and calibration. Two further lines carry serial messages. For every accepted trigger, one lane sends the event number and the bunch-crossing number, and the other lane sends the 8-bit trigger type. Both messages start with a framing bit and are sent least significant bit first. The two remaining lines are spares and stay high.

The block holds a 24-bit event counter and a bunch-crossing counter. The bunch-crossing counter advances on every clock and wraps at a parameterized orbit length. Each serial lane can hold one extra message while it is still sending. If a trigger arrives when that holding slot is already full, the trigger is dropped on that lane and a one-cycle overflow flag is raised. An asynchronous active-low busy input coming back from the receiver passes through a two-stage synchronizer and is presented as an active-high status.

Requests are plain single-cycle control inputs with no back-pressure. The block accepts a request in every cycle. The overflow flag is the only sign that a serial message was lost, so the upstream trigger source must space its triggers if it needs every message delivered.

Top module: `ttbus_tx`

## Requirements
- R1: While reset is held, and right after it is released, all eight bus lines are high, `busy` is 0 and `q_overflow` is 0.
- R2: A `trig_req` sampled at a clock edge drives line 0 low for exactly the one cycle following that edge.
- R3: `ecr_req`, `bcr_req` and `cal_req` drive lines 1, 2 and 3 low in the same way as R2. Lines 6 and 7 are always high.
- R4: Line 4 sends the identifier message. The message is a start bit (logical 1, line low), then the 24-bit event number, then the 12-bit bunch number, 37 bit times in all, each field LSB first, with logical 1 shown as line low. For a trigger that finds the lane idle, the start bit is on the line in the second cycle after the request edge.
- R5: Line 5 sends the trigger-type message. The message is a start bit, then the 8-bit trigger type LSB first, then 2 reserved bits of logical 0 (line high), 11 bit times in all.
- R6: Each serial line is high for at least one cycle before every start bit, including between back-to-back messages.
- R7: The first trigger after reset, or after the cycle in which an event-counter reset is requested, carries event number 0. Each later trigger carries one more, and dropped triggers are counted as well.
- R8: The bunch number is 0 in the cycle after reset or after a bunch-counter reset request. It rises by 1 each clock and wraps from `ORBIT_LEN-1` to 0. A trigger carries the bunch number of the cycle in which it is requested.
- R9: A trigger that arrives while a lane is sending is held in a one-deep slot. It is sent after the current message and a one-cycle gap.
- R10: A trigger that arrives while a lane is sending and its slot is full is dropped on that lane. `q_overflow` is then high for the one cycle following that request edge.
- R11: `busy` equals the inverse of `busy_n_async` delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_req | input | 1 | Trigger accept request, one cycle per trigger |
| trig_type | input | 8 | Trigger type, sampled with `trig_req` |
| ecr_req | input | 1 | Event-counter reset request |
| bcr_req | input | 1 | Bunch-counter reset request |
| cal_req | input | 1 | Calibration request |
| busy_n_async | input | 1 | Asynchronous active-low busy from the receiver |
| bus_n | output | 8 | Active-low timing and trigger bus |
| busy | output | 1 | Synchronized busy, active high |
| q_overflow | output | 1 | One-cycle pulse when a serial message is dropped |

## Verification
The assertions assume that reset is asserted at time zero, before any request is applied. They also assume that request inputs are valid at every clock edge, and that an event-counter reset and a trigger are never requested in the same cycle. Any other input pattern is allowed, including triggers on consecutive cycles. The stimulus drives every input only at the falling edge, never raises the two counter-reset requests together with a trigger, and uses a short orbit length so that bunch wrap-around occurs many times in one run. Busy toggles are applied between messages so they do not overlap any check of the serial lanes.

// File: rtl/ttbus_pkg.sv
package ttbus_pkg;
  localparam int BUS_W      = 8;
  localparam int LN_TRIG    = 0;
  localparam int LN_ECR     = 1;
  localparam int LN_BCR     = 2;
  localparam int LN_CAL     = 3;
  localparam int LN_IDMSG   = 4;
  localparam int LN_TTMSG   = 5;
  localparam int LN_SPARE   = 6;
  localparam int LN_UNUSED  = 7;
  localparam int N_CMD      = 4;
  localparam int EV_W_DEF   = 24;
  localparam int BC_W_DEF   = 12;
  localparam int TT_W_DEF   = 8;
  localparam int TT_RSV_DEF = 2;
endpackage

// File: rtl/ttbus_cnt.sv
module ttbus_cnt #(
  parameter int EV_W      = 24,
  parameter int BC_W      = 12,
  parameter int ORBIT_LEN = 3564
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            ecr,
  input  logic            bcr,
  output logic [EV_W-1:0] ev_tag,
  output logic [BC_W-1:0] bc_tag
);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(ORBIT_LEN - 1);

  logic [EV_W-1:0] ev_q;
  logic [BC_W-1:0] bc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      bc_q <= '0;
    end else begin
      if (ecr)       ev_q <= '0;
      else if (trig) ev_q <= ev_q + EV_W'(1);
      if (bcr || bc_q == BC_LAST) bc_q <= '0;
      else                        bc_q <= bc_q + BC_W'(1);
    end
  end

  assign ev_tag = ev_q;
  assign bc_tag = bc_q;

  // R8
  bc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) bc_q <= BC_LAST);
  // R8
  bc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_q == BC_LAST && !bcr) |=> bc_q == '0);
  // R7
  ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) ecr |=> ev_q == '0);
  // R7
  ev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ecr) |=> ev_q == $past(ev_q) + EV_W'(1));
endmodule

// File: rtl/ttbus_ser.sv
module ttbus_ser #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] data,
  output logic              line,
  output logic              ovf
);
  localparam int FW = DATA_W + 1;
  localparam int RW = $clog2(FW + 1);

  logic [FW-1:0]     sr;
  logic [RW-1:0]     rem;
  logic              q_vld;
  logic [DATA_W-1:0] q_dat;
  logic              line_q;
  logic              ovf_q;
  logic              idle;

  assign idle = (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      rem    <= '0;
      q_vld  <= 1'b0;
      q_dat  <= '0;
      line_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (idle) begin
        line_q <= 1'b0;
        if (q_vld) begin
          sr    <= {q_dat, 1'b1};
          rem   <= RW'(FW);
          q_vld <= push;
          if (push) q_dat <= data;
        end else if (push) begin
          sr  <= {data, 1'b1};
          rem <= RW'(FW);
        end
      end else begin
        line_q <= sr[0];
        sr     <= sr >> 1;
        rem    <= rem - RW'(1);
        if (push) begin
          if (!q_vld) begin
            q_vld <= 1'b1;
            q_dat <= data;
          end else begin
            ovf_q <= 1'b1;
          end
        end
      end
    end
  end

  assign line = line_q;
  assign ovf  = ovf_q;

  // R6
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (q_vld || push)) |=> (line_q == 1'b0) ##1 (line_q == 1'b1));
  // R9
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> rem == $past(rem) - RW'(1));
  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> ($past(q_vld) && $past(rem) != '0));
endmodule

// File: rtl/ttbus_sync.sv
module ttbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/ttbus_tx.sv
module ttbus_tx
  import ttbus_pkg::*;
#(
  parameter int ORBIT_LEN   = 3564,
  parameter int EV_W        = EV_W_DEF,
  parameter int BC_W        = BC_W_DEF,
  parameter int TT_W        = TT_W_DEF,
  parameter int TT_RSV_W    = TT_RSV_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_req,
  input  logic [TT_W-1:0]  trig_type,
  input  logic             ecr_req,
  input  logic             bcr_req,
  input  logic             cal_req,
  input  logic             busy_n_async,
  output logic [BUS_W-1:0] bus_n,
  output logic             busy,
  output logic             q_overflow
);
  localparam int ID_W  = EV_W + BC_W;
  localparam int TTM_W = TT_W + TT_RSV_W;

  logic [EV_W-1:0]  ev_tag;
  logic [BC_W-1:0]  bc_tag;
  logic [ID_W-1:0]  id_data;
  logic [TTM_W-1:0] tt_data;
  logic             id_line, tt_line, id_ovf, tt_ovf;
  logic [N_CMD-1:0] cmd_q;
  logic             busy_n_s;

  ttbus_cnt #(.EV_W(EV_W), .BC_W(BC_W), .ORBIT_LEN(ORBIT_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .trig(trig_req), .ecr(ecr_req), .bcr(bcr_req),
    .ev_tag(ev_tag), .bc_tag(bc_tag)
  );

  assign id_data = {bc_tag, ev_tag};
  assign tt_data = {{TT_RSV_W{1'b0}}, trig_type};

  ttbus_ser #(.DATA_W(ID_W)) u_id_ser (
    .clk(clk), .rst_n(rst_n), .push(trig_req), .data(id_data),
    .line(id_line), .ovf(id_ovf)
  );

  ttbus_ser #(.DATA_W(TTM_W)) u_tt_ser (
    .clk(clk), .rst_n(rst_n), .push(trig_req), .data(tt_data),
    .line(tt_line), .ovf(tt_ovf)
  );

  ttbus_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .din(busy_n_async), .dout(busy_n_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= {cal_req, bcr_req, ecr_req, trig_req};
  end

  always_comb begin
    bus_n            = '1;
    bus_n[LN_TRIG]   = ~cmd_q[0];
    bus_n[LN_ECR]    = ~cmd_q[1];
    bus_n[LN_BCR]    = ~cmd_q[2];
    bus_n[LN_CAL]    = ~cmd_q[3];
    bus_n[LN_IDMSG]  = ~id_line;
    bus_n[LN_TTMSG]  = ~tt_line;
    bus_n[LN_SPARE]  = 1'b1;
    bus_n[LN_UNUSED] = 1'b1;
  end

  assign busy       = ~busy_n_s;
  assign q_overflow = id_ovf | tt_ovf;

  // R2
  trig_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_n[LN_TRIG] |-> $past(trig_req));
  // R3
  cal_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_n[LN_CAL] |-> $past(cal_req));
  // R10
  ovf_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow |-> $past(trig_req));
endmodule

// File: tb/ttbus_tx_bench.sv
module ttbus_tx_bench;
  localparam int ORB = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig_req, ecr_req, bcr_req, cal_req, busy_n_async;
  logic [7:0] trig_type;
  logic [7:0] bus_n;
  logic       busy, q_overflow;

  int checks = 0;
  int fails  = 0;
  int bmod   = 0;
  int ev     = 0;
  logic [35:0] id_exp[$];
  logic [9:0]  tt_exp[$];

  always #10 clk = ~clk;

  ttbus_tx #(.ORBIT_LEN(ORB)) u_ttbus_tx (
    .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .trig_type(trig_type),
    .ecr_req(ecr_req), .bcr_req(bcr_req), .cal_req(cal_req),
    .busy_n_async(busy_n_async), .bus_n(bus_n), .busy(busy), .q_overflow(q_overflow)
  );

  // bunch model from R8
  always @(posedge clk) begin
    if (!rst_n || bcr_req) bmod <= 0;
    else                   bmod <= (bmod == ORB - 1) ? 0 : bmod + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // push expected messages and fire one trigger; checks R2 strobe
  task automatic fire(input logic [7:0] t, input bit drop);
    trig_req  = 1'b1;
    trig_type = t;
    if (!drop) begin
      id_exp.push_back({bmod[11:0], ev[23:0]});
      tt_exp.push_back({2'b00, t});
    end
    ev++;
    @(negedge clk);
    trig_req = 1'b0;
    chk(bus_n[0] == 1'b0, "R2 accept strobe", bus_n[0], 0);
  endtask

  task automatic pulse(input int which, input logic [7:0] exp_bus);
    if (which == 1) ecr_req = 1'b1;
    if (which == 2) bcr_req = 1'b1;
    if (which == 3) cal_req = 1'b1;
    @(negedge clk);
    ecr_req = 1'b0; bcr_req = 1'b0; cal_req = 1'b0;
    if (which == 1) ev = 0;
    chk(bus_n == exp_bus, "R3 command strobe", bus_n, exp_bus);
    @(negedge clk);
    chk(bus_n == 8'hFF, "R3 strobe lasts one cycle, spares high", bus_n, 8'hFF);
  endtask

  // ID lane monitor (R4, R6)
  initial begin
    forever begin : id_mon
      logic [35:0] got;
      logic [35:0] exp;
      @(negedge clk);
      if (rst_n === 1'b1 && bus_n[4] === 1'b0) begin
        for (int i = 0; i < 36; i++) begin
          @(negedge clk);
          got[i] = ~bus_n[4];
        end
        if (id_exp.size() == 0) chk(1'b0, "R4 unexpected id message", got, 0);
        else begin
          exp = id_exp.pop_front();
          chk(got == exp, "R4 R7 R8 id message", got, exp);
        end
        @(negedge clk);
        chk(bus_n[4] == 1'b1, "R6 id gap", bus_n[4], 1);
      end
    end
  end

  // trigger-type lane monitor (R5, R6)
  initial begin
    forever begin : tt_mon
      logic [9:0] got;
      logic [9:0] exp;
      @(negedge clk);
      if (rst_n === 1'b1 && bus_n[5] === 1'b0) begin
        for (int i = 0; i < 10; i++) begin
          @(negedge clk);
          got[i] = ~bus_n[5];
        end
        if (tt_exp.size() == 0) chk(1'b0, "R5 unexpected type message", got, 0);
        else begin
          exp = tt_exp.pop_front();
          chk(got == exp, "R5 type message", got, exp);
        end
        @(negedge clk);
        chk(bus_n[5] == 1'b1, "R6 type gap", bus_n[5], 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; trig_req = 1'b0; trig_type = '0;
    ecr_req = 1'b0; bcr_req = 1'b0; cal_req = 1'b0; busy_n_async = 1'b1;
    idle(3);
    // R1
    chk(bus_n == 8'hFF && !busy && !q_overflow, "R1 reset state", {busy, q_overflow, bus_n}, 10'h0FF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_n == 8'hFF, "R1 after release", bus_n, 8'hFF);

    // R2, R4, R5, R7: isolated triggers, event numbers from 0
    fire(8'hA5, 1'b0);
    idle(60);
    fire(8'h3C, 1'b0);
    idle(45);
    fire(8'hFF, 1'b0);
    idle(50);

    // R3: each command line
    pulse(3, 8'hF7);
    pulse(2, 8'hFB);
    // R8: bunch after reset and wrap
    idle(5);
    fire(8'h01, 1'b0);
    idle(55);
    pulse(1, 8'hFD);
    // R7: first trigger after counter reset carries 0
    idle(2);
    fire(8'h80, 1'b0);
    idle(50);

    // R9: second trigger queued behind a busy id lane
    fire(8'h11, 1'b0);
    idle(20);
    fire(8'h22, 1'b0);
    idle(90);

    // R10: three triggers in a row, third dropped on both lanes
    fire(8'h05, 1'b0);
    fire(8'h06, 1'b0);
    chk(q_overflow == 1'b0, "R10 no overflow with free slot", q_overflow, 0);
    fire(8'h07, 1'b1);
    chk(q_overflow == 1'b1, "R10 overflow pulse", q_overflow, 1);
    @(negedge clk);
    chk(q_overflow == 1'b0, "R10 overflow lasts one cycle", q_overflow, 0);
    idle(100);
    // R7: dropped trigger still counted
    fire(8'h42, 1'b0);
    idle(50);

    // R11: busy synchronizer latency
    busy_n_async = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy after one edge", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R11 busy after two edges", busy, 1);
    busy_n_async = 1'b1;
    idle(1);
    chk(busy == 1'b1, "R11 release after one edge", busy, 1);
    idle(1);
    chk(busy == 1'b0, "R11 release after two edges", busy, 0);

    idle(20);
    chk(id_exp.size() == 0, "R4 all id messages seen", id_exp.size(), 0);
    chk(tt_exp.size() == 0, "R5 all type messages seen", tt_exp.size(), 0);
    chk(bus_n == 8'hFF, "R3 bus idle high", bus_n, 8'hFF);
    finish_run();
  end
endmodule